// File: doc/BRIEF.md
# Pulse Signature Detector

This block watches one digital signal and decides whether it follows a fixed, ordered list of pulse constraints once a start pulse has armed it. Each constraint names a level (low, high or don't-care) and a duration in clock cycles. The duration is either one exact width, or a minimum and a maximum for pulses whose exact width is not known in advance. A state machine walks the constraints in order. It reports a one-cycle `detected` pulse when the final constraint is satisfied, and a one-cycle `mismatch` pulse as soon as any constraint is broken.

The constraint list and the signature's marking are elaboration parameters. A signature marked valid describes correct behaviour. A signature marked invalid describes a known fault. `hit_valid` carries that marking alongside each detection, so a monitor built from several detectors can tell good activity from bad. Level codes are 2'b00 low, 2'b01 high and 2'b10 don't-care. A constraint is exact when its minimum equals its maximum, and ranged otherwise.

Top module: `psd_detector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `detected`, `mismatch` and `hit_valid` are low and the detector is idle.
- R2: Checking starts only when `start_pulse` is sampled high while idle. The first sample checked is `mon_sig` at the next rising edge. With no start pulse, neither output ever rises.
- R3: Constraints are checked in index order, from 0 up. An exact low/high constraint (level 2'b00 or 2'b01) passes after exactly its width of matching samples. A non-matching sample before that raises `mismatch`.
- R4: A ranged low/high constraint ends at the first sample whose level differs. It passes if the count of matching samples is between min and max inclusive, and raises `mismatch` if the count is below min.
- R5: A ranged low/high constraint raises `mismatch` on the sample that would bring its count to max+1.
- R6: A don't-care constraint (level 2'b10) passes once its minimum width of samples has elapsed, whatever the signal does.
- R7: `detected` rises for exactly one cycle, in the cycle after the edge at which the last constraint passes. `hit_valid` equals the signature marking whenever `detected` is high, and is low otherwise.
- R8: `detected` and `mismatch` are single-cycle pulses and are never high in the same cycle.
- R9: A `start_pulse` that arrives while a check is in progress has no effect on the result or its timing.
- R10: After either outcome the detector is idle at once. A start pulse in the very next cycle begins a new check.
- R11: The sample that ends a ranged constraint counts as the first sample of the following constraint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_sig | input | 1 | Monitored signal |
| start_pulse | input | 1 | Arms a check when idle |
| detected | output | 1 | One-cycle pulse: last constraint passed |
| mismatch | output | 1 | One-cycle pulse: a constraint was broken |
| hit_valid | output | 1 | Signature marking, shown while `detected` is high |

## Verification
The bench targets the edges of each constraint kind:
- A ranged low phase held for exactly its minimum, for exactly its maximum, and one cycle past the maximum. A design with an off-by-one bound would detect where it should fail, or fail one cycle late.
- The handoff sample that ends a ranged phase. If that sample were dropped or counted twice, the don't-care phase that follows would shift, and a correct stream would be reported as a mismatch.
- An exact phase held one cycle too long or too short, and a wrong first level.
- Don't-care phases driven with both values.
- A start pulse injected mid-check, and checks run back to back with no idle gap. A design that restarts on a late start pulse, or needs a spare cycle to return to idle, would report at the wrong cycle or miss a check entirely.

// File: rtl/psd_pkg.sv
package psd_pkg;

   // level codes of one constraint
   typedef enum logic [1:0] {
      LV_LOW  = 2'b00,
      LV_HIGH = 2'b01,
      LV_ANY  = 2'b10
   } lvl_t;

   // outcome of evaluating one sample against one constraint
   typedef enum logic [1:0] {
      EV_HOLD    = 2'b00,  // still inside the constraint
      EV_DONE    = 2'b01,  // passed, this sample consumed
      EV_HANDOFF = 2'b10,  // passed, this sample belongs to the next one
      EV_FAIL    = 2'b11   // constraint broken
   } ev_t;

endpackage

// File: rtl/psd_cons_sel.sv
module psd_cons_sel #(
   parameter int N_CONS = 4,
   parameter int CNT_W  = 8,
   parameter int IDX_W  = 2,
   parameter logic [N_CONS*2-1:0]     LVL_VEC = '0,
   parameter logic [N_CONS*CNT_W-1:0] MIN_VEC = '0,
   parameter logic [N_CONS*CNT_W-1:0] MAX_VEC = '0
) (
   input  logic [IDX_W-1:0] idx,
   output logic [1:0]       lvl,
   output logic [CNT_W-1:0] wmin,
   output logic [CNT_W-1:0] wmax
);

   always_comb begin
      lvl  = LVL_VEC[1:0];
      wmin = MIN_VEC[CNT_W-1:0];
      wmax = MAX_VEC[CNT_W-1:0];
      for (int k = 0; k < N_CONS; k++) begin
         if (int'(idx) == k) begin
            lvl  = LVL_VEC[k*2 +: 2];
            wmin = MIN_VEC[k*CNT_W +: CNT_W];
            wmax = MAX_VEC[k*CNT_W +: CNT_W];
         end
      end
   end

endmodule

// File: rtl/psd_eval.sv
module psd_eval
   import psd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [1:0]       lvl,
   input  logic [CNT_W-1:0] wmin,
   input  logic [CNT_W-1:0] wmax,
   input  logic [CNT_W-1:0] cnt,
   input  logic             sample,
   output ev_t              ev,
   output logic [CNT_W:0]   nxt_cnt
);

   logic exact;
   logic lvl_hit;

   assign exact   = (wmin == wmax);
   assign lvl_hit = (sample == lvl[0]);
   assign nxt_cnt = {1'b0, cnt} + 1'b1;

   always_comb begin
      ev = EV_HOLD;
      if (lvl == LV_ANY) begin
         if (nxt_cnt >= {1'b0, wmin}) ev = EV_DONE;
      end else if (exact) begin
         if (!lvl_hit)                        ev = EV_FAIL;
         else if (nxt_cnt == {1'b0, wmax})    ev = EV_DONE;
      end else begin
         if (lvl_hit) begin
            if (nxt_cnt > {1'b0, wmax})       ev = EV_FAIL;
         end else if (cnt >= wmin) begin
            ev = EV_HANDOFF;
         end else begin
            ev = EV_FAIL;
         end
      end
   end

endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
   import psd_pkg::*;
#(
   parameter int N_CONS = 4,
   parameter int CNT_W  = 8,
   parameter int IDX_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_pulse,
   input  ev_t              ev_cur,
   input  logic [CNT_W:0]   nc_cur,
   input  ev_t              ev_nxt,
   input  logic [CNT_W:0]   nc_nxt,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic [CNT_W-1:0] cnt,
   output logic             detected,
   output logic             mismatch
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CONS - 1);

   logic is_last;
   assign is_last = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         idx      <= '0;
         cnt      <= '0;
         detected <= 1'b0;
         mismatch <= 1'b0;
      end else begin
         detected <= 1'b0;
         mismatch <= 1'b0;
         if (!busy) begin
            if (start_pulse) begin
               busy <= 1'b1;
               idx  <= '0;
               cnt  <= '0;
            end
         end else begin
            unique case (ev_cur)
               EV_HOLD: cnt <= nc_cur[CNT_W-1:0];
               EV_FAIL: begin
                  mismatch <= 1'b1;
                  busy     <= 1'b0;
                  idx      <= '0;
                  cnt      <= '0;
               end
               EV_DONE: begin
                  cnt <= '0;
                  if (is_last) begin
                     detected <= 1'b1;
                     busy     <= 1'b0;
                     idx      <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               EV_HANDOFF: begin
                  if (is_last) begin
                     detected <= 1'b1;
                     busy     <= 1'b0;
                     idx      <= '0;
                     cnt      <= '0;
                  end else if (ev_nxt == EV_FAIL) begin
                     mismatch <= 1'b1;
                     busy     <= 1'b0;
                     idx      <= '0;
                     cnt      <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                     cnt <= nc_nxt[CNT_W-1:0];
                  end
               end
               default: cnt <= cnt;
            endcase
         end
      end
   end

endmodule

// File: rtl/psd_detector.sv
module psd_detector
   import psd_pkg::*;
#(
   parameter int N_CONS    = 4,
   parameter int CNT_W     = 8,
   parameter bit SIG_VALID = 1'b1,
   // constraint k occupies slice k; index 0 is checked first
   parameter logic [N_CONS*2-1:0]     LVL_VEC = {2'b01, 2'b10, 2'b00, 2'b01},
   parameter logic [N_CONS*CNT_W-1:0] MIN_VEC = {8'd1, 8'd2, 8'd2, 8'd3},
   parameter logic [N_CONS*CNT_W-1:0] MAX_VEC = {8'd3, 8'd2, 8'd4, 8'd3}
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_sig,
   input  logic start_pulse,
   output logic detected,
   output logic mismatch,
   output logic hit_valid
);

   localparam int IDX_W = (N_CONS > 1) ? $clog2(N_CONS) : 1;

   // elaboration-time parameter checks
   if (N_CONS < 1) begin : g_bad_n
      $error("psd_detector: N_CONS must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("psd_detector: CNT_W must be at least 2");
   end
   for (genvar k = 0; k < N_CONS; k++) begin : g_chk
      localparam logic [1:0]       LV = LVL_VEC[k*2 +: 2];
      localparam logic [CNT_W-1:0] MN = MIN_VEC[k*CNT_W +: CNT_W];
      localparam logic [CNT_W-1:0] MX = MAX_VEC[k*CNT_W +: CNT_W];
      if (LV == 2'b11) begin : g_bad_lvl
         $error("psd_detector: level code 2'b11 is reserved");
      end
      if (MN == '0 || MN > MX) begin : g_bad_rng
         $error("psd_detector: width needs 1 <= min <= max");
      end
      if (k > 0) begin : g_follow
         localparam logic [1:0]       PLV = LVL_VEC[(k-1)*2 +: 2];
         localparam logic [CNT_W-1:0] PMN = MIN_VEC[(k-1)*CNT_W +: CNT_W];
         localparam logic [CNT_W-1:0] PMX = MAX_VEC[(k-1)*CNT_W +: CNT_W];
         if (PLV != 2'b10 && PMN != PMX && (LV == 2'b10 || MN == MX) && MN < 2)
         begin : g_bad_follow
            $error("psd_detector: a constraint after a ranged level needs min >= 2");
         end
      end
   end

   logic             busy_w;
   logic [IDX_W-1:0] idx_w;
   logic [IDX_W-1:0] idx_nxt;
   logic [CNT_W-1:0] cnt_w;
   logic [1:0]       lvl_cur, lvl_nxt;
   logic [CNT_W-1:0] min_cur, min_nxt;
   logic [CNT_W-1:0] cur_max, max_nxt;
   ev_t              ev_cur, ev_nxt;
   logic [CNT_W:0]   nc_cur, nc_nxt;

   assign idx_nxt = (int'(idx_w) < N_CONS - 1) ? idx_w + 1'b1 : idx_w;

   psd_cons_sel #(
      .N_CONS(N_CONS), .CNT_W(CNT_W), .IDX_W(IDX_W),
      .LVL_VEC(LVL_VEC), .MIN_VEC(MIN_VEC), .MAX_VEC(MAX_VEC)
   ) u_sel_cur (
      .idx(idx_w), .lvl(lvl_cur), .wmin(min_cur), .wmax(cur_max)
   );

   psd_cons_sel #(
      .N_CONS(N_CONS), .CNT_W(CNT_W), .IDX_W(IDX_W),
      .LVL_VEC(LVL_VEC), .MIN_VEC(MIN_VEC), .MAX_VEC(MAX_VEC)
   ) u_sel_nxt (
      .idx(idx_nxt), .lvl(lvl_nxt), .wmin(min_nxt), .wmax(max_nxt)
   );

   psd_eval #(.CNT_W(CNT_W)) u_eval_cur (
      .lvl(lvl_cur), .wmin(min_cur), .wmax(cur_max), .cnt(cnt_w),
      .sample(mon_sig), .ev(ev_cur), .nxt_cnt(nc_cur)
   );

   // first-sample view of the following constraint, used on handoff
   psd_eval #(.CNT_W(CNT_W)) u_eval_nxt (
      .lvl(lvl_nxt), .wmin(min_nxt), .wmax(max_nxt), .cnt('0),
      .sample(mon_sig), .ev(ev_nxt), .nxt_cnt(nc_nxt)
   );

   psd_ctrl #(.N_CONS(N_CONS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
      .ev_cur(ev_cur), .nc_cur(nc_cur), .ev_nxt(ev_nxt), .nc_nxt(nc_nxt),
      .busy(busy_w), .idx(idx_w), .cnt(cnt_w),
      .detected(detected), .mismatch(mismatch)
   );

   if (SIG_VALID) begin : g_tag_valid
      assign hit_valid = detected;
   end else begin : g_tag_invalid
      assign hit_valid = 1'b0;
   end

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             detected,
   input logic             mismatch,
   input logic             busy,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cur_max
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!detected && !mismatch)
            else $error("outputs active during reset");
      end
   end

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(detected && mismatch));

   assert_det_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      detected |=> !detected);

   assert_mis_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> !mismatch);

   assert_outcome_from_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (detected || mismatch) |-> $past(busy));

   assert_idle_after_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (detected || mismatch) |-> !busy);

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= cur_max));

endmodule

bind psd_detector psd_checker #(.CNT_W(CNT_W)) u_psd_checker (
   .clk(clk), .rst_n(rst_n), .detected(detected), .mismatch(mismatch),
   .busy(busy_w), .cnt(cnt_w), .cur_max(cur_max)
);

// File: tb/psd_detector_bench.sv
module psd_detector_bench;

   typedef struct {
      int    cyc;
      bit    det;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_sig = 1'b0;
   logic start_pulse = 1'b0;
   logic detected, mismatch, hit_valid;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_errors = 0;
   int   n_events = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   psd_detector u_psd_detector (
      .clk(clk), .rst_n(rst_n), .mon_sig(mon_sig), .start_pulse(start_pulse),
      .detected(detected), .mismatch(mismatch), .hit_valid(hit_valid)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   // driver: start pulse, then one character of s per cycle; last char decides
   task automatic run(string s, bit det, int restart_at, string req);
      exp_t e;
      @(negedge clk);
      start_pulse = 1'b1;
      mon_sig     = 1'b0;
      for (int i = 0; i < s.len(); i++) begin
         @(negedge clk);
         start_pulse = (i == restart_at);
         mon_sig     = (s[i] == "1");
         if (i == s.len() - 1) begin
            e.cyc = cyc + 1;
            e.det = det;
            e.req = req;
            exp_q.push_back(e);
         end
      end
      start_pulse = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
            exp_t m;
            m = exp_q.pop_front();
            n_checks++;
            n_errors++;
            $display("FAIL %s: no outcome at cycle %0d (actual none, expected det=%0d)",
                     m.req, m.cyc, m.det);
         end
         if (detected || mismatch) begin
            n_events++;
            n_checks++;
            if (exp_q.size() == 0) begin
               n_errors++;
               $display("FAIL R2: unexpected outcome at cycle %0d (actual det=%0d mis=%0d, expected none)",
                        cyc, detected, mismatch);
            end else begin
               exp_t g;
               g = exp_q.pop_front();
               if (g.cyc != cyc || detected != g.det || mismatch != !g.det
                   || hit_valid != g.det) begin
                  n_errors++;
                  $display("FAIL %s: actual cyc=%0d det=%0d mis=%0d tag=%0d, expected cyc=%0d det=%0d mis=%0d tag=%0d",
                           g.req, cyc, detected, mismatch, hit_valid,
                           g.cyc, g.det, !g.det, g.det);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual run still going, expected finish");
      summary();
      $finish;
   end

   initial begin
      int ev0;
      repeat (3) @(negedge clk);
      n_checks++;
      if (detected || mismatch || hit_valid) begin
         n_errors++;
         $display("FAIL R1: actual det=%0d mis=%0d tag=%0d, expected 0 0 0",
                  detected, mismatch, hit_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (detected || mismatch || hit_valid) begin
         n_errors++;
         $display("FAIL R1: after release det=%0d mis=%0d, expected 0 0", detected, mismatch);
      end

      // R2: toggling signal without start produces nothing
      ev0 = n_events;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         mon_sig = i[0] ^ i[2];
      end
      repeat (2) @(negedge clk);
      n_checks++;
      if (n_events != ev0) begin
         n_errors++;
         $display("FAIL R2: actual %0d outcomes without start, expected 0", n_events - ev0);
      end

      // back-to-back checks, no idle gap (R10)
      run("111001010",   1'b1, -1, "R11");   // nominal, handoff sample counted
      run("11100001110", 1'b1, -1, "R4");    // low phase at max width
      run("11100000",    1'b0, -1, "R5");    // low phase past max
      run("11101",       1'b0, -1, "R4");    // low phase below min
      run("110",         1'b0, -1, "R3");    // exact phase too short
      run("0",           1'b0, -1, "R3");    // wrong first level
      run("1111",        1'b0, -1, "R3");    // exact phase too long
      run("11100101111", 1'b0, -1, "R5");    // last ranged phase past max
      run("111001110",   1'b1, -1, "R6");    // don't-care sampled high
      run("11100101110", 1'b1, -1, "R7");    // last ranged phase at max
      run("111001010",   1'b1,  2, "R9");    // start pulse mid-check
      run("111001010",   1'b1,  6, "R10");   // start pulse late in check
      repeat (5) @(negedge clk);
      run("111001010",   1'b1, -1, "R10");   // after a gap
      repeat (6) @(negedge clk);

      n_checks++;
      if (exp_q.size() != 0) begin
         n_errors++;
         $display("FAIL R7: actual %0d outcomes missing, expected 0", exp_q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule